// File: doc/BRIEF.md
# Low-Power Idle Entry and Wake Timer Controller

This block decides when an Ethernet transmit path may start sending the low-power idle pattern toward the PHY, and when it may go back to ordinary frames. Two conditions gate entry. The link must have been reported up without a break for a programmed number of milliseconds, and software must request low-power idle. Once the idle pattern stops, ordinary transmission stays blocked for a programmed number of microseconds so that the far end can wake up.

A small register interface holds the two times. When the wake period ends, the block sets a sticky exit status bit. Software clears that bit by writing a one to it. Time is derived from the core clock by parameterised prescalers: `CYC_PER_US` core cycles make one microsecond and `US_PER_MS` microseconds make one millisecond.

The controller has three states, visited in a fixed order:
- NORMAL: ordinary transmission is allowed.
- LPI_ACTIVE: the idle pattern is driven.
- WAKE_WAIT: the wake time is counted.

The transitions are:
- ENTER (NORMAL→LPI_ACTIVE): LPI is enabled and the link-stable condition holds.
- LEAVE (LPI_ACTIVE→WAKE_WAIT): LPI enable drops, an exit request arrives, or the link drops.
- RESUME (WAKE_WAIT→NORMAL): the wake count reaches the programmed value.

Top module: `lpi_timer_ctrl`

## Requirements
- R1: After reset, the configuration word reads 0x03E80000, which is a hold time of 1000 ms and a wake time of 0. The status word reads 0, `tx_lpi` is 0 and `tx_resume_ok` is 1.
- R2: The configuration word (`reg_sel`=0) holds the link hold time in milliseconds at bits 25:16 and the wake time in microseconds at bits 15:0. Bits 31:26 always read as 0, whatever was written to them.
- R3: Suppose `link_up` and `lpi_en` are both high and have been high since the link timer was last cleared. Then `tx_lpi` first reads 1 after the (H·CYC_PER_US·US_PER_MS+1)-th rising edge, where H is the hold time. It stays 0 before that edge.
- R4: A low `link_up` clears the link timer. After the link returns, the R3 count starts again from zero.
- R5: In LPI_ACTIVE, `tx_lpi` falls at the next edge if any of these holds: `lpi_en` is low, `lpi_exit_req` is high, or `link_up` is low.
- R6: Let W be the wake time. `tx_resume_ok` rises W·CYC_PER_US+1 cycles after `tx_lpi` falls. With W=0, it rises on the cycle right after the fall.
- R7: `lpi_exit_flag` is set at the same edge at which `tx_resume_ok` rises. It stays set until it is cleared.
- R8: The status word (`reg_sel`=1) shows the exit flag at bit 0. Writing it with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 has no effect on the flag.
- R9: `tx_lpi` and `tx_resume_ok` are never high together. States follow NORMAL→LPI_ACTIVE→WAKE_WAIT→NORMAL only.
- R10: While `lpi_en` is low, `tx_lpi` stays 0 however long the link is stable. Raising `lpi_en` once the hold has elapsed makes `tx_lpi` read 1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 = timer configuration word, 1 = status word |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| lpi_en | input | 1 | Software request for low-power idle |
| link_up | input | 1 | PHY link-up indication |
| lpi_exit_req | input | 1 | Request to leave low-power idle |
| tx_lpi | output | 1 | Drive the idle pattern toward the PHY |
| tx_resume_ok | output | 1 | Ordinary transmission permitted |
| lpi_exit_flag | output | 1 | Sticky wake-period-expired status |

## Verification
The assertions assume that `rst_n` is held low across the first clock edge. They also assume that every input changes only away from the rising edge, so each input is seen as steady for a whole cycle. The bench drives all inputs on the falling edge and starts with reset low at time zero. It sweeps small hold and wake values with short prescale divisors, and it rotates through the three ways of leaving LPI_ACTIVE. This lets every exit path and every counter boundary be reached within the run.

// File: rtl/lpi_timer_pkg.sv
package lpi_timer_pkg;
    localparam int HOLD_W   = 10;
    localparam int WAKE_W   = 16;
    localparam int HOLD_LSB = 16;
    localparam int HOLD_RST = 1000;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_LPI       = 2'd1,
        ST_WAKE_WAIT = 2'd2
    } lpi_state_e;
endpackage

// File: rtl/lpi_tick_div.sv
module lpi_tick_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    assign tick = en && (cnt == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lpi_link_timer.sv
module lpi_link_timer #(
    parameter int CYC_PER_US = 125,
    parameter int US_PER_MS  = 1000,
    parameter int HOLD_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic [HOLD_W-1:0] hold_ms,
    output logic              link_ok
);
    logic us_tick;
    logic ms_tick;
    logic [HOLD_W-1:0] ms_cnt;

    lpi_tick_div #(.DIV(CYC_PER_US)) u_us_div (
        .clk(clk), .rst_n(rst_n), .clr(!link_up), .en(link_up), .tick(us_tick)
    );

    lpi_tick_div #(.DIV(US_PER_MS)) u_ms_div (
        .clk(clk), .rst_n(rst_n), .clr(!link_up), .en(us_tick), .tick(ms_tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !link_up) begin
            ms_cnt <= '0;
        end else if (ms_tick && (ms_cnt != '1)) begin
            ms_cnt <= ms_cnt + 1'b1;
        end
    end

    assign link_ok = link_up && (ms_cnt >= hold_ms);

    // R4: a dropped link leaves the millisecond count at zero
    a_r4_link_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (ms_cnt == '0));
endmodule

// File: rtl/lpi_wake_timer.sv
module lpi_wake_timer #(
    parameter int CYC_PER_US = 125,
    parameter int WAKE_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WAKE_W-1:0] wake_us,
    output logic              done
);
    logic us_tick;
    logic [WAKE_W-1:0] us_cnt;

    lpi_tick_div #(.DIV(CYC_PER_US)) u_us_div (
        .clk(clk), .rst_n(rst_n), .clr(!run), .en(run), .tick(us_tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            us_cnt <= '0;
        end else if (us_tick && (us_cnt != '1)) begin
            us_cnt <= us_cnt + 1'b1;
        end
    end

    assign done = run && (us_cnt >= wake_us);
endmodule

// File: rtl/lpi_cfg_regs.sv
module lpi_cfg_regs
    import lpi_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              set_flag,
    output logic [HOLD_W-1:0] hold_ms,
    output logic [WAKE_W-1:0] wake_us,
    output logic              exit_flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_ms <= HOLD_W'(HOLD_RST);
            wake_us <= '0;
        end else if (reg_wr && !reg_sel) begin
            hold_ms <= reg_wdata[HOLD_LSB +: HOLD_W];
            wake_us <= reg_wdata[WAKE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_flag <= 1'b0;
        end else if (set_flag) begin
            exit_flag <= 1'b1;
        end else if (reg_wr && reg_sel && reg_wdata[0]) begin
            exit_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[0] = exit_flag;
        end else begin
            reg_rdata[HOLD_LSB +: HOLD_W] = hold_ms;
            reg_rdata[WAKE_W-1:0]         = wake_us;
        end
    end
endmodule

// File: rtl/lpi_timer_ctrl.sv
module lpi_timer_ctrl
    import lpi_timer_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int US_PER_MS  = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lpi_en,
    input  logic        link_up,
    input  logic        lpi_exit_req,
    output logic        tx_lpi,
    output logic        tx_resume_ok,
    output logic        lpi_exit_flag
);
    lpi_state_e state, state_nx;
    logic [HOLD_W-1:0] hold_ms;
    logic [WAKE_W-1:0] wake_us;
    logic link_ok;
    logic wake_done;
    logic set_flag;

    lpi_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_flag(set_flag),
        .hold_ms(hold_ms), .wake_us(wake_us), .exit_flag(lpi_exit_flag)
    );

    lpi_link_timer #(.CYC_PER_US(CYC_PER_US), .US_PER_MS(US_PER_MS), .HOLD_W(HOLD_W)) u_link (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .hold_ms(hold_ms), .link_ok(link_ok)
    );

    lpi_wake_timer #(.CYC_PER_US(CYC_PER_US), .WAKE_W(WAKE_W)) u_wake (
        .clk(clk), .rst_n(rst_n), .run(state == ST_WAKE_WAIT),
        .wake_us(wake_us), .done(wake_done)
    );

    assign set_flag = (state == ST_WAKE_WAIT) && wake_done;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NORMAL:    if (lpi_en && link_ok) state_nx = ST_LPI;
            ST_LPI:       if (!lpi_en || lpi_exit_req || !link_up) state_nx = ST_WAKE_WAIT;
            ST_WAKE_WAIT: if (wake_done) state_nx = ST_NORMAL;
            default:      state_nx = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= state_nx;
    end

    always_comb begin
        tx_lpi       = 1'b0;
        tx_resume_ok = 1'b0;
        unique case (state)
            ST_NORMAL:    tx_resume_ok = 1'b1;
            ST_LPI:       tx_lpi       = 1'b1;
            ST_WAKE_WAIT: ;
            default:      ;
        endcase
    end

    // R9: pattern and resume permission are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_lpi && tx_resume_ok));
    // R9: LPI_ACTIVE is only left toward WAKE_WAIT
    a_r9_lpi_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LPI) |=> (state == ST_LPI || state == ST_WAKE_WAIT));
    // R9: WAKE_WAIT never jumps back to LPI_ACTIVE
    a_r9_wake_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE_WAIT) |=> (state != ST_LPI));
    // R3: the pattern starts only after a stable link and an enable
    a_r3_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_lpi) |-> $past(link_ok && lpi_en));
    // R5: a link drop during LPI leaves it at the next edge
    a_r5_exit_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lpi && !link_up) |=> !tx_lpi);
    // R7: resuming always comes with the exit flag set
    a_r7_flag_on_resume: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_resume_ok) && $past(state == ST_WAKE_WAIT)) |-> lpi_exit_flag);
endmodule

// File: tb/lpi_timer_ctrl_test.sv
module lpi_timer_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int C = 2;
    localparam int U = 3;
    localparam int N = C * U;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_sel = 1'b0;
    logic reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic lpi_en = 1'b0;
    logic link_up = 1'b0;
    logic lpi_exit_req = 1'b0;
    logic tx_lpi, tx_resume_ok, lpi_exit_flag;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpi_timer_ctrl #(.CYC_PER_US(C), .US_PER_MS(U)) uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lpi_en(lpi_en),
        .link_up(link_up), .lpi_exit_req(lpi_exit_req), .tx_lpi(tx_lpi),
        .tx_resume_ok(tx_resume_ok), .lpi_exit_flag(lpi_exit_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    // edges from now until tx_lpi reads 1 (limit returns 9999)
    task automatic count_entry(output int k);
        k = 9999;
        for (int i = 1; i <= 8000; i++) begin
            @(posedge clk); #1;
            if (tx_lpi) begin k = i; break; end
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 tx_lpi", {31'b0, tx_lpi}, 0);
        chk("R1 resume", {31'b0, tx_resume_ok}, 1);
        chk("R1 flag", {31'b0, lpi_exit_flag}, 0);
        rd_reg(1'b0, rd); chk("R1 cfg", rd, 32'h03E8_0000);
        rd_reg(1'b1, rd); chk("R1 status", rd, 0);

        // R3 with the reset hold of 1000 ms
        @(negedge clk); link_up = 1'b1; lpi_en = 1'b1;
        count_entry(k);
        chk("R3 default hold", k, 1000 * N + 1);
        @(negedge clk); lpi_en = 1'b0; link_up = 1'b0;
        repeat (3) @(negedge clk);

        // R2 layout and reserved bits
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd_reg(1'b0, rd); chk("R2 reserved zero", rd, 32'h03FF_FFFF);
        wr_reg(1'b0, 32'h0155_1234);
        rd_reg(1'b0, rd); chk("R2 fields", rd, 32'h0155_1234);

        // sweep: hold 0..4, wake 0..5, three exit reasons
        for (int h = 0; h <= 4; h++) begin
            for (int w = 0; w <= 5; w++) begin
                for (int r = 0; r < 3; r++) begin
                    int m;
                    wr_reg(1'b0, (32'(h) << 16) | 32'(w));
                    @(negedge clk); link_up = 1'b1; lpi_en = 1'b1;
                    count_entry(k);
                    chk($sformatf("R3 entry h=%0d", h), k, h * N + 1);
                    @(negedge clk);
                    if (r == 0) lpi_en = 1'b0;
                    else if (r == 1) lpi_exit_req = 1'b1;
                    else link_up = 1'b0;
                    @(posedge clk); #1;
                    chk($sformatf("R5 leave r=%0d", r), {30'b0, tx_lpi, tx_resume_ok}, 0);
                    @(negedge clk); lpi_en = 1'b0; lpi_exit_req = 1'b0;
                    m = 9999;
                    for (int i = 2; i <= 200; i++) begin
                        @(posedge clk); #1;
                        if (tx_resume_ok) begin m = i; break; end
                        if (lpi_exit_flag) begin
                            chk("R7 early flag", 1, 0);
                        end
                    end
                    // R6: resume w*C+1 cycles after the fall
                    chk($sformatf("R6 wake w=%0d", w), m, w * C + 2);
                    chk("R7 flag set", {31'b0, lpi_exit_flag}, 1);
                    repeat (2) @(negedge clk);
                    chk("R7 sticky", {31'b0, lpi_exit_flag}, 1);
                    if (r == 0) begin
                        wr_reg(1'b1, 32'hFFFF_FFFE);
                        rd_reg(1'b1, rd); chk("R8 write zero ignored", rd, 1);
                    end
                    wr_reg(1'b1, 32'h1);
                    rd_reg(1'b1, rd); chk("R8 w1c", rd, 0);
                    @(negedge clk); link_up = 1'b0;
                    @(negedge clk);
                end
            end
        end

        // R4 link drop restarts the hold count
        wr_reg(1'b0, 32'h0002_0000);
        @(negedge clk); link_up = 1'b1; lpi_en = 1'b1;
        repeat (8) @(posedge clk);
        #1; chk("R4 before drop", {31'b0, tx_lpi}, 0);
        @(negedge clk); link_up = 1'b0;
        @(negedge clk); link_up = 1'b1;
        count_entry(k);
        chk("R4 restart", k, 2 * N + 1);
        @(negedge clk); lpi_en = 1'b0;
        repeat (3) @(negedge clk);
        wr_reg(1'b1, 32'h1);

        // R10 no entry without enable
        @(negedge clk); link_up = 1'b0;
        @(negedge clk); link_up = 1'b1;
        repeat (2 * N + 10) @(posedge clk);
        #1; chk("R10 no entry", {30'b0, tx_lpi, tx_resume_ok}, 1);
        @(negedge clk); lpi_en = 1'b1;
        @(posedge clk); #1;
        chk("R10 entry next edge", {31'b0, tx_lpi}, 1);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule